// File: doc/BRIEF.md
# DMA Channel Register Bank

This block holds the software-visible setup of four DMA channels: one source address, one destination address and one control/count word per channel. Every write is trimmed to the bits that matter, and a count of zero is turned into the channel's maximum transfer length. A separate transfer engine reads the working copies of the addresses and the count. The engine also reports when a block has finished, and this bank then does the end-of-block handling.

Working copies of the addresses and the count are taken only when a channel's enable bit goes from 0 to 1. A channel set to immediate timing raises its start request a fixed number of cycles after that write. The lowest-numbered requesting channel is reported as the active one. Other timing codes are stored but never raise a request. A parameter chooses between a wide variant, with a 21-bit count, and a narrow variant, with a 16-bit count.

Byte offsets: channel c has its source at c*12, its destination at c*12+4 and its control/count word at c*12+8. In the control/count word, bits 31..16 are the control half:

| Field | Bits |
|---|---|
| enable | 31 |
| interrupt enable | 30 |
| timing (0 = immediate) | 29..27 |
| repeat | 25 |
| destination mode (3 = increment with reload) | 22..21 |

In the same word, bits 20..0 (wide variant) or bits 15..0 (narrow variant) carry the count.

Top module: `dma_regfile`

## Requirements
- R1: A source or destination write stores only bits 27..1. Bits 31..28 and bit 0 always read back as 0.
- R2: Wide variant: the count is data bits 20..0. A count of 0 decodes to 0x200000, and any other value is kept unchanged.
- R3: Narrow variant: the count is data bits 15..0. A count of 0 decodes to 0x10000 on channel 3 and to 0x4000 on channels 0 to 2.
- R4: The control half is stored through mask 0xFFE0 (wide variant) or 0xF7E0 (narrow variant). A read of the control/count offset returns {control half, 16'h0000}.
- R5: Only a 0-to-1 change of enable copies source, destination and the decoded count into the working copies. Writing again while the channel is enabled leaves the working copies unchanged.
- R6: An enabling write with timing 0 at clock edge k raises that channel's start request after edge k+3, and not before. A non-zero timing code never raises a request.
- R7: At end of block on an enabled channel, enable is cleared when repeat is 0 or timing is 0, and a read shows the cleared bit. Otherwise enable stays set. The working count is cleared and the start request is dropped.
- R8: At end of block, destination mode 3 restores the working destination from the destination register. Other modes leave it unchanged.
- R9: At end of block with interrupt enable set, the channel's interrupt line is high for exactly one cycle. With interrupt enable clear, the line stays low.
- R10: After reset all registers and working copies read 0, every decoded count is 0x200000, and no request, interrupt or active channel is shown.
- R11: The active output names the lowest-numbered channel whose start request is high. The valid flag is low when no channel requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Read byte offset |
| rd_data | output | 32 | Read data (combinational) |
| eob_valid | input | 1 | End-of-block report from the transfer engine |
| eob_ch | input | 2 | Channel that finished its block |
| sel_ch | input | 2 | Channel shown on the sel_* outputs |
| sel_src | output | 32 | Working source of the selected channel |
| sel_dst | output | 32 | Working destination of the selected channel |
| sel_cfg_cnt | output | 22 | Decoded programmed count of the selected channel |
| sel_work_cnt | output | 22 | Working count of the selected channel |
| start_req | output | 4 | Per-channel start request |
| irq | output | 4 | Per-channel end-of-block interrupt pulse |
| act_valid | output | 1 | Some channel is requesting |
| act_ch | output | 2 | Lowest-numbered requesting channel |

## Verification
Address masking is checked with all-ones patterns, with patterns that set only the stripped bits, and with ordinary values. These show apart masking of the high bits and masking of bit 0. The count decoder is given zero, small, full-width and out-of-field values in both variants. This separates the zero substitution from truncation of the field and from channel-3 special handling. End-of-block reports are sent with repeat off, with repeat plus immediate timing, and with repeat plus non-immediate timing, and the reload mode is tried against a destination changed after enabling. This separates the clear-enable rule, the reload path and the interrupt gating. Overlapping immediate starts on two channels show the priority order and the three-cycle start delay.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;
    localparam int CNT_W  = 22;

    // control-half bit positions
    localparam int B_EN    = 15;
    localparam int B_IRQ   = 14;
    localparam int B_TIMHI = 13;
    localparam int B_TIMLO = 11;
    localparam int B_REP   = 9;
    localparam int B_DSTHI = 6;
    localparam int B_DSTLO = 5;

    localparam logic [1:0]        DST_RELOAD = 2'b11;
    localparam logic [WORD_W-1:0] ADDR_KEEP  = 32'h0FFF_FFFE;

    function automatic logic [CNT_W-1:0] cnt_decode(
        input logic              wide,
        input logic              last_ch,
        input logic [WORD_W-1:0] d
    );
        logic [CNT_W-1:0] r;
        if (wide) begin
            r = (d[20:0] == '0) ? 22'h20_0000 : {1'b0, d[20:0]};
        end else if (d[15:0] == '0) begin
            r = last_ch ? 22'h01_0000 : 22'h00_4000;
        end else begin
            r = {6'b0, d[15:0]};
        end
        return r;
    endfunction

endpackage

// File: rtl/dma_rf_chan.sv
module dma_rf_chan
    import dma_rf_pkg::*;
#(
    parameter int CH        = 0,
    parameter int WIDE      = 1,
    parameter int LAST_CH   = 3,
    parameter int START_DLY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_src,
    input  logic              wr_dst,
    input  logic              wr_ctl,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              eob,
    output logic [WORD_W-1:0] src_o,
    output logic [WORD_W-1:0] dst_o,
    output logic [HALF_W-1:0] ctl_o,
    output logic [WORD_W-1:0] wsrc_o,
    output logic [WORD_W-1:0] wdst_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  wcnt_o,
    output logic              start_o,
    output logic              irq_o
);

    localparam int          DLY_W    = $clog2(START_DLY + 1);
    localparam logic [15:0] CTL_MASK = (WIDE != 0) ? 16'hFFE0 : 16'hF7E0;
    localparam logic        IS_LAST  = (CH == LAST_CH);

    typedef struct packed {
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] wsrc;
        logic [WORD_W-1:0] wdst;
        logic [HALF_W-1:0] ctl;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  wcnt;
        logic [DLY_W-1:0]  dly;
        logic              arm;
        logic              irq;
    } chan_st_t;

    chan_st_t s_q, s_d;
    logic     en_rise_d, imm_q, imm_new_d;

    always_comb begin
        s_d       = s_q;
        s_d.irq   = 1'b0;
        imm_q     = (s_q.ctl[B_TIMHI:B_TIMLO] == '0);
        en_rise_d = 1'b0;
        imm_new_d = 1'b0;

        if (s_q.dly != '0) begin
            s_d.dly = s_q.dly - 1'b1;
        end

        if (eob && s_q.ctl[B_EN]) begin
            if (!s_q.ctl[B_REP] || imm_q) begin
                s_d.ctl[B_EN] = 1'b0;
            end
            if (s_q.ctl[B_DSTHI:B_DSTLO] == DST_RELOAD) begin
                s_d.wdst = s_q.dst;
            end
            s_d.irq  = s_q.ctl[B_IRQ];
            s_d.wcnt = '0;
            s_d.arm  = 1'b0;
        end

        if (wr_src) begin
            s_d.src = wr_data & ADDR_KEEP;
        end
        if (wr_dst) begin
            s_d.dst = wr_data & ADDR_KEEP;
        end

        if (wr_ctl) begin
            s_d.ctl   = wr_data[WORD_W-1:HALF_W] & CTL_MASK;
            s_d.cnt   = cnt_decode(WIDE != 0, IS_LAST, wr_data);
            en_rise_d = s_d.ctl[B_EN] && !s_q.ctl[B_EN];
            imm_new_d = (s_d.ctl[B_TIMHI:B_TIMLO] == '0);
        end

        if (en_rise_d) begin
            s_d.wsrc = s_q.src;
            s_d.wdst = s_q.dst;
            s_d.wcnt = s_d.cnt;
            s_d.arm  = imm_new_d;
            s_d.dly  = DLY_W'(START_DLY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.cnt <= 22'h20_0000;
        end else begin
            s_q <= s_d;
        end
    end

    assign src_o   = s_q.src;
    assign dst_o   = s_q.dst;
    assign ctl_o   = s_q.ctl;
    assign wsrc_o  = s_q.wsrc;
    assign wdst_o  = s_q.wdst;
    assign cnt_o   = s_q.cnt;
    assign wcnt_o  = s_q.wcnt;
    assign start_o = s_q.ctl[B_EN] && s_q.arm && (s_q.dly == '0);
    assign irq_o   = s_q.irq;

    // cycles since the last enabling write, saturating (checking aid)
    logic [7:0] since_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (en_rise_d) begin
            since_q <= '0;
        end else if (since_q != 8'hFF) begin
            since_q <= since_q + 1'b1;
        end
    end

    a_r1_addr_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (src_o[0] == 1'b0) && (src_o[31:28] == 4'h0) && (dst_o[0] == 1'b0) && (dst_o[31:28] == 4'h0));

    a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && ctl_o[B_EN] && !eob) |=> ($stable(wsrc_o) && $stable(wcnt_o)));

    a_r6_start_delay: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (32'(since_q) >= START_DLY - 1));

    a_r7_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (eob && ctl_o[B_EN] && !wr_ctl && (!ctl_o[B_REP] || (ctl_o[B_TIMHI:B_TIMLO] == '0)))
        |=> !ctl_o[B_EN]);

    a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(eob));

endmodule

// File: rtl/dma_rf_arb.sv
module dma_rf_arb #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IW'(i);
            end
        end
    end

    a_r11_pick_requesting: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> req[idx]);

    a_r11_valid_any: assert property (@(posedge clk) disable iff (!rst_n)
        valid == (req != '0));

endmodule

// File: rtl/dma_rf_rdmux.sv
module dma_rf_rdmux
    import dma_rf_pkg::*;
#(
    parameter int N     = 4,
    parameter int AW    = 6,
    parameter int STRIDE = 12
) (
    input  logic [AW-1:0]       rd_addr,
    input  logic [N*WORD_W-1:0] src_flat,
    input  logic [N*WORD_W-1:0] dst_flat,
    input  logic [N*HALF_W-1:0] ctl_flat,
    output logic [WORD_W-1:0]   rd_data
);

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < N; c++) begin
            if (rd_addr == AW'(c * STRIDE)) begin
                rd_data = src_flat[c*WORD_W +: WORD_W];
            end
            if (rd_addr == AW'(c * STRIDE + 4)) begin
                rd_data = dst_flat[c*WORD_W +: WORD_W];
            end
            if (rd_addr == AW'(c * STRIDE + 8)) begin
                rd_data = {ctl_flat[c*HALF_W +: HALF_W], 16'h0000};
            end
        end
    end

endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_rf_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int WIDE      = 1,
    parameter int AW        = 6,
    parameter int START_DLY = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [31:0]               wr_data,
    input  logic [AW-1:0]             rd_addr,
    output logic [31:0]               rd_data,
    input  logic                      eob_valid,
    input  logic [$clog2(NUM_CH)-1:0] eob_ch,
    input  logic [$clog2(NUM_CH)-1:0] sel_ch,
    output logic [31:0]               sel_src,
    output logic [31:0]               sel_dst,
    output logic [21:0]               sel_cfg_cnt,
    output logic [21:0]               sel_work_cnt,
    output logic [NUM_CH-1:0]         start_req,
    output logic [NUM_CH-1:0]         irq,
    output logic                      act_valid,
    output logic [$clog2(NUM_CH)-1:0] act_ch
);

    localparam int STRIDE = 12;
    localparam int CW     = $clog2(NUM_CH);

    logic [NUM_CH*WORD_W-1:0] src_flat, dst_flat;
    logic [NUM_CH*HALF_W-1:0] ctl_flat;
    logic [WORD_W-1:0]        wsrc_a [NUM_CH];
    logic [WORD_W-1:0]        wdst_a [NUM_CH];
    logic [CNT_W-1:0]         cnt_a  [NUM_CH];
    logic [CNT_W-1:0]         wcnt_a [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic w_src, w_dst, w_ctl, e_hit;
        assign w_src = wr_en && (wr_addr == AW'(c * STRIDE));
        assign w_dst = wr_en && (wr_addr == AW'(c * STRIDE + 4));
        assign w_ctl = wr_en && (wr_addr == AW'(c * STRIDE + 8));
        assign e_hit = eob_valid && (eob_ch == CW'(c));

        dma_rf_chan #(
            .CH        (c),
            .WIDE      (WIDE),
            .LAST_CH   (NUM_CH - 1),
            .START_DLY (START_DLY)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_src  (w_src),
            .wr_dst  (w_dst),
            .wr_ctl  (w_ctl),
            .wr_data (wr_data),
            .eob     (e_hit),
            .src_o   (src_flat[c*WORD_W +: WORD_W]),
            .dst_o   (dst_flat[c*WORD_W +: WORD_W]),
            .ctl_o   (ctl_flat[c*HALF_W +: HALF_W]),
            .wsrc_o  (wsrc_a[c]),
            .wdst_o  (wdst_a[c]),
            .cnt_o   (cnt_a[c]),
            .wcnt_o  (wcnt_a[c]),
            .start_o (start_req[c]),
            .irq_o   (irq[c])
        );
    end

    dma_rf_rdmux #(
        .N      (NUM_CH),
        .AW     (AW),
        .STRIDE (STRIDE)
    ) u_rdmux (
        .rd_addr  (rd_addr),
        .src_flat (src_flat),
        .dst_flat (dst_flat),
        .ctl_flat (ctl_flat),
        .rd_data  (rd_data)
    );

    dma_rf_arb #(
        .N  (NUM_CH),
        .IW (CW)
    ) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (start_req),
        .valid (act_valid),
        .idx   (act_ch)
    );

    assign sel_src      = wsrc_a[sel_ch];
    assign sel_dst      = wdst_a[sel_ch];
    assign sel_cfg_cnt  = cnt_a[sel_ch];
    assign sel_work_cnt = wcnt_a[sel_ch];

endmodule

// File: tb/dma_regfile_tb.sv
module dma_regfile_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic        eob_valid = 1'b0;
    logic [1:0]  eob_ch = '0;
    logic [1:0]  sel_ch = '0;

    logic [31:0] rd_data, sel_src, sel_dst;
    logic [21:0] sel_cfg_cnt, sel_work_cnt;
    logic [3:0]  start_req, irq;
    logic        act_valid;
    logic [1:0]  act_ch;

    logic [31:0] n_rd_data, n_src, n_dst;
    logic [21:0] n_cfg_cnt, n_work_cnt;
    logic [3:0]  n_start, n_irq;
    logic        n_act_valid;
    logic [1:0]  n_act_ch;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    dma_regfile #(.WIDE(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .eob_valid(eob_valid), .eob_ch(eob_ch),
        .sel_ch(sel_ch), .sel_src(sel_src), .sel_dst(sel_dst), .sel_cfg_cnt(sel_cfg_cnt),
        .sel_work_cnt(sel_work_cnt), .start_req(start_req), .irq(irq),
        .act_valid(act_valid), .act_ch(act_ch)
    );

    dma_regfile #(.WIDE(0)) u_dut_n (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(n_rd_data), .eob_valid(eob_valid), .eob_ch(eob_ch),
        .sel_ch(sel_ch), .sel_src(n_src), .sel_dst(n_dst), .sel_cfg_cnt(n_cfg_cnt),
        .sel_work_cnt(n_work_cnt), .start_req(n_start), .irq(n_irq),
        .act_valid(n_act_valid), .act_ch(n_act_ch)
    );

    typedef struct packed {
        logic [5:0]  a;
        logic [31:0] d;
        logic [31:0] e;
    } vec_t;

    // R1 / R4 write-then-read vectors for the wide variant
    localparam vec_t VECS [8] = '{
        '{6'd0,  32'hFFFF_FFFF, 32'h0FFF_FFFE},
        '{6'd4,  32'h1234_5679, 32'h0234_5678},
        '{6'd12, 32'hF000_0001, 32'h0000_0000},
        '{6'd16, 32'h8ACE_1357, 32'h0ACE_1356},
        '{6'd8,  32'h7FFF_FFFF, 32'h7FE0_0000},
        '{6'd20, 32'h001F_0000, 32'h0000_0000},
        '{6'd44, 32'h1234_5678, 32'h1220_0000},
        '{6'd40, 32'h0000_0003, 32'h0000_0002}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic eob(input logic [1:0] ch);
        @(negedge clk);
        eob_valid = 1'b1; eob_ch = ch;
        @(negedge clk);
        eob_valid = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] w, output logic [31:0] n);
        rd_addr = a;
        #1;
        w = rd_data;
        n = n_rd_data;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] w, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();

        // R10: reset state
        rd(6'd0, w, n);  chk("R10 src reset", w, 0);
        rd(6'd44, w, n); chk("R10 ctl reset", w, 0);
        for (int c = 0; c < 4; c++) begin
            sel_ch = 2'(c); #1;
            chk("R10 count reset", sel_cfg_cnt, 22'h200000);
            chk("R10 work reset", sel_work_cnt, 0);
        end
        chk("R10 no request", start_req, 0);
        chk("R10 no irq", irq, 0);
        chk("R10 no active", act_valid, 0);

        // R1 / R4 vector walk
        for (int i = 0; i < 8; i++) begin
            wr(VECS[i].a, VECS[i].d);
            rd(VECS[i].a, w, n);
            chk((VECS[i].a % 12 == 8) ? "R4 ctl mask" : "R1 addr mask", w, VECS[i].e);
        end

        // R2: wide count decode on channel 2
        sel_ch = 2'd2;
        wr(6'd32, 32'h0000_0000); #1; chk("R2 zero count", sel_cfg_cnt, 22'h200000);
        wr(6'd32, 32'h0000_0005); #1; chk("R2 small count", sel_cfg_cnt, 22'h5);
        wr(6'd32, 32'h001F_FFFF); #1; chk("R2 full count", sel_cfg_cnt, 22'h1FFFFF);
        wr(6'd32, 32'h0020_0007); #1; chk("R2 bit21 outside", sel_cfg_cnt, 22'h7);

        // R5 / R6: immediate start on channel 1
        sel_ch = 2'd1;
        wr(6'd12, 32'h0000_0100);
        wr(6'd16, 32'h0000_0200);
        wr(6'd20, 32'h8000_0004);
        #1;
        chk("R5 wsrc load", sel_src, 32'h100);
        chk("R5 wdst load", sel_dst, 32'h200);
        chk("R5 wcnt load", sel_work_cnt, 22'h4);
        chk("R6 low at k", start_req[1], 0);
        step(); chk("R6 low at k+1", start_req[1], 0);
        step(); chk("R6 low at k+2", start_req[1], 0);
        step(); chk("R6 high at k+3", start_req[1], 1);
        chk("R11 active ch1", {act_valid, act_ch}, {1'b1, 2'd1});
        wr(6'd12, 32'h0000_0300);
        wr(6'd20, 32'h8000_0009);
        #1;
        chk("R5 no reload src", sel_src, 32'h100);
        chk("R5 no reload cnt", sel_work_cnt, 22'h4);
        chk("R5 cfg updated", sel_cfg_cnt, 22'h9);

        // R11: channel 0 overtakes channel 1 after its start delay
        wr(6'd8, 32'h8000_0002);
        step(); step();
        chk("R11 still ch1", {act_valid, act_ch}, {1'b1, 2'd1});
        step();
        chk("R11 now ch0", {act_valid, act_ch}, {1'b1, 2'd0});

        // R7 / R9: end of block, repeat off, no interrupt
        eob(2'd0);
        rd(6'd8, w, n);
        chk("R7 enable cleared", w, 32'h0);
        chk("R9 no irq", irq[0], 0);
        chk("R11 back to ch1", {act_valid, act_ch}, {1'b1, 2'd1});

        // R7 / R9: repeat with immediate timing clears, irq pulses
        wr(6'd32, 32'hC200_0001);
        eob(2'd2);
        chk("R9 irq high", irq, 4'b0100);
        rd(6'd32, w, n);
        chk("R7 rep+imm cleared", w, 32'h4200_0000);
        step();
        chk("R9 irq one cycle", irq, 4'b0000);

        // R6 / R7: repeat with non-immediate timing
        wr(6'd44, 32'h8A00_0001);
        repeat (4) step();
        chk("R6 non-immediate no request", start_req[3], 0);
        eob(2'd3);
        rd(6'd44, w, n);
        chk("R7 rep kept enabled", w, 32'h8A00_0000);
        chk("R9 no irq ch3", irq[3], 0);

        // R8: destination reload
        eob(2'd1);
        #1;
        chk("R7 wcnt cleared", sel_work_cnt, 0);
        chk("R8 no reload mode0", sel_dst, 32'h200);
        chk("R7 request dropped", start_req[1], 0);
        wr(6'd16, 32'h0000_0500);
        wr(6'd20, 32'h8060_0003);
        #1; chk("R8 wdst at enable", sel_dst, 32'h500);
        wr(6'd16, 32'h0000_0700);
        #1; chk("R8 wdst held", sel_dst, 32'h500);
        eob(2'd1);
        #1; chk("R8 wdst reloaded", sel_dst, 32'h700);
        rd(6'd20, w, n);
        chk("R7 ch1 cleared", w, 32'h0060_0000);
        chk("R11 none active", act_valid, 0);

        // R3 / R4: narrow variant
        wr(6'd8, 32'h7FFF_0000);
        rd(6'd8, w, n);
        chk("R4 narrow mask", n, 32'h77E0_0000);
        sel_ch = 2'd0; #1;
        chk("R3 zero ch0", n_cfg_cnt, 22'h4000);
        wr(6'd44, 32'h0000_0000);
        sel_ch = 2'd3; #1;
        chk("R3 zero ch3", n_cfg_cnt, 22'h10000);
        wr(6'd20, 32'h0001_0009);
        sel_ch = 2'd1; #1;
        chk("R3 narrow field", n_cfg_cnt, 22'h9);
        chk("R2 wide field", sel_cfg_cnt, 22'h10009);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
            $finish;
        end
    end

endmodule